// File: doc/BRIEF.md
# Word-wide table-driven CRC-32 engine

This block accumulates a reflected CRC-32 over a stream of 32-bit words, taking one word per clock. Each accepted word is XORed into the running remainder. The 32-bit result is cut into four bytes, and each byte addresses its own 256-entry lookup table. The four table outputs are XORed to give the next remainder. The lookup for the last byte of the word on the wire uses the table that holds the CRC of each single byte. Each byte further back in the word uses a table that carries that CRC forward over one more zero byte per step back. Constant functions compute every table entry at elaboration, so no memory image is needed.

A message begins with a word presented with `start_i` high. In that cycle the remainder is taken from the all-ones preset instead of from the register. Every accepted word updates a registered CRC output, which is the bitwise inverse of the remainder. The output therefore always holds the finished CRC of the message so far. Idle cycles between words are allowed. Partial trailing words are not handled.

Top module: `crc32_slice4`

## Requirements
- R1: After reset, `crc_valid_o` is 0, `crc_o` is 0, and the remainder holds the all-ones preset.
- R2: A word with `valid_i` and `start_i` both high produces, one clock later, `crc_valid_o` = 1 and `crc_o` = the standard CRC-32 of that word. The CRC uses the reflected polynomial 0xEDB88320, an all-ones preset and an inverted output. Byte 0 (`data_i[7:0]`) is the first byte on the wire, and each byte is taken least significant bit first.
- R3: Each word accepted with `valid_i` high and `start_i` low continues the message. One clock later, `crc_o` equals the CRC-32 of every byte accepted since the last start.
- R4: In a cycle with `valid_i` low and `start_i` low, the remainder does not change. `crc_valid_o` is 0 the next cycle and `crc_o` keeps its value.
- R5: `start_i` with a word in the middle of a message discards the earlier bytes. The result covers only the bytes from that word on.
- R6: `start_i` high with `valid_i` low loads the all-ones preset and produces no output. The following word without start is then the first word of a new message.
- R7: The word 0x00000000 sent on its own yields `crc_o` = 0x2144DF1C.
- R8: Any number of idle cycles between words leaves the final CRC unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a new message from the preset |
| valid_i | input | 1 | `data_i` holds a word to absorb |
| data_i | input | 32 | Input word, byte 0 first on the wire |
| crc_o | output | 32 | Inverted remainder after the latest word |
| crc_valid_o | output | 1 | `crc_o` was updated by a word in the previous cycle |

## Verification
The hardest cases to reach are the ones where the preset is loaded without a word, and where a restart lands in the middle of a message. Only there does the remainder's source differ from both the register and the plain preset-with-word path. The stimulus covers these with directed sequences: a lone start, a start followed by idle cycles before the first word, and restarts inside long random messages. Randomly placed idle cycles break up the word stream. A bit-serial model in the bench follows every clock, so a wrong table for any single byte position shows up as a mismatch.

// File: rtl/crc_slice_pkg.sv
package crc_slice_pkg;
  localparam int CRC_W   = 32;
  localparam int BYTE_W  = 8;
  localparam int N_SLICE = CRC_W / BYTE_W;
  localparam int TBL_D   = 1 << BYTE_W;

  typedef logic [CRC_W-1:0] crc_t;

  // shift a remainder through BYTE_W zero bits of the reflected division
  function automatic crc_t zero_byte_step(input crc_t value, input crc_t poly);
    crc_t r;
    r = value;
    for (int b = 0; b < BYTE_W; b++) begin
      if (r[0]) r = (r >> 1) ^ poly;
      else      r = r >> 1;
    end
    return r;
  endfunction

  // entry of the table that cancels a byte lying 'ahead' bytes before the word end
  function automatic crc_t slice_entry(input int idx, input int ahead, input crc_t poly);
    crc_t r;
    r = crc_t'(idx);
    r = zero_byte_step(r, poly);
    for (int k = 0; k < ahead; k++) r = zero_byte_step(r, poly);
    return r;
  endfunction
endpackage

// File: rtl/crc_slice_rom.sv
module crc_slice_rom
  import crc_slice_pkg::*;
#(
  parameter int   AHEAD = 0,
  parameter crc_t POLY  = 32'hEDB88320
) (
  input  logic [BYTE_W-1:0] addr_i,
  output crc_t              data_o
);
  crc_t rom [TBL_D];

  genvar e;
  generate
    for (e = 0; e < TBL_D; e++) begin : g_entry
      localparam crc_t ENTRY = slice_entry(e, AHEAD, POLY);
      assign rom[e] = ENTRY;
    end
  endgenerate

  assign data_o = rom[addr_i];
endmodule

// File: rtl/crc_slice_fold.sv
module crc_slice_fold
  import crc_slice_pkg::*;
#(
  parameter crc_t POLY = 32'hEDB88320
) (
  input  crc_t rem_i,
  input  crc_t word_i,
  output crc_t next_o
);
  crc_t mix;
  crc_t part [N_SLICE];
  crc_t acc  [N_SLICE+1];

  assign mix    = rem_i ^ word_i;
  assign acc[0] = '0;

  genvar s;
  generate
    for (s = 0; s < N_SLICE; s++) begin : g_slice
      // byte s is followed by N_SLICE-1-s bytes of this word on the wire
      crc_slice_rom #(
        .AHEAD (N_SLICE - 1 - s),
        .POLY  (POLY)
      ) i_rom (
        .addr_i (mix[s*BYTE_W +: BYTE_W]),
        .data_o (part[s])
      );
      assign acc[s+1] = acc[s] ^ part[s];
    end
  endgenerate

  assign next_o = acc[N_SLICE];
endmodule

// File: rtl/crc32_slice4.sv
module crc32_slice4
  import crc_slice_pkg::*;
#(
  parameter crc_t POLY     = 32'hEDB88320,
  parameter crc_t PRESET   = 32'hFFFFFFFF,
  parameter crc_t OUT_MASK = 32'hFFFFFFFF
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start_i,
  input  logic        valid_i,
  input  logic [31:0] data_i,
  output logic [31:0] crc_o,
  output logic        crc_valid_o
);
  crc_t rem_q;
  crc_t base;
  crc_t next_rem;

  assign base = start_i ? PRESET : rem_q;

  crc_slice_fold #(.POLY(POLY)) i_fold (
    .rem_i  (base),
    .word_i (data_i),
    .next_o (next_rem)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q       <= PRESET;
      crc_o       <= '0;
      crc_valid_o <= 1'b0;
    end else begin
      crc_valid_o <= valid_i;
      if (valid_i) begin
        rem_q <= next_rem;
        crc_o <= next_rem ^ OUT_MASK;
      end else if (start_i) begin
        rem_q <= PRESET;
      end
    end
  end

  // R4
  hold_rem_chk: assert property (@(posedge clk) disable iff (rst)
    (!valid_i && !start_i) |=> $stable(rem_q));

  // R4
  hold_out_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> ($stable(crc_o) && !crc_valid_o));

  // R2
  out_flag_chk: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> crc_valid_o);

  // R3
  out_match_chk: assert property (@(posedge clk) disable iff (rst)
    crc_valid_o |-> (crc_o == (rem_q ^ OUT_MASK)));

  // R6
  preset_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && !valid_i) |=> (rem_q == PRESET));

  // R2
  zero_map_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_i && (base == data_i)) |-> (next_rem == '0));
endmodule

// File: tb/test_crc32_slice4.sv
`timescale 1ns/1ps
module test_crc32_slice4;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] data_i = '0;
  logic [31:0] crc_o;
  logic        crc_valid_o;

  int n_tests = 0;
  int n_fail  = 0;

  logic [31:0] ref_rem;
  logic [31:0] exp_crc;
  logic        exp_v;

  always #2.5 clk = ~clk;

  crc32_slice4 i_crc32_slice4 (
    .clk(clk), .rst(rst), .start_i(start_i), .valid_i(valid_i),
    .data_i(data_i), .crc_o(crc_o), .crc_valid_o(crc_valid_o)
  );

  function automatic logic [31:0] serial_word(input logic [31:0] r0, input logic [31:0] w);
    logic [31:0] r;
    logic fb;
    r = r0;
    for (int i = 0; i < 32; i++) begin
      fb = r[0] ^ w[i];
      r  = r >> 1;
      if (fb) r = r ^ 32'hEDB88320;
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  // drive at negedge, clock once, compare at the next negedge
  task automatic step(input logic s, input logic v, input logic [31:0] d, input string tag);
    logic [31:0] b;
    start_i = s; valid_i = v; data_i = d;
    @(posedge clk);
    b = s ? 32'hFFFFFFFF : ref_rem;
    if (v) begin
      ref_rem = serial_word(b, d);
      exp_crc = ~ref_rem;
    end else begin
      ref_rem = b;
    end
    exp_v = v;
    @(negedge clk);
    check({tag, " valid"}, {31'd0, crc_valid_o}, {31'd0, exp_v});
    check({tag, " crc"}, crc_o, exp_crc);
  endtask

  initial begin
    #(200000 * 5);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] saved;
    ref_rem = 32'hFFFFFFFF; exp_crc = '0; exp_v = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 valid", {31'd0, crc_valid_o}, 32'd0);
    check("R1 crc", crc_o, 32'd0);
    // R1 preset: first word without start uses all-ones
    step(1'b0, 1'b1, 32'h34333231, "R1 preset word");
    // R7 zero word constant
    step(1'b1, 1'b1, 32'h00000000, "R7");
    check("R7 const", crc_o, 32'h2144DF1C);
    // R2 single words of various patterns
    step(1'b1, 1'b1, 32'hFFFFFFFF, "R2 ones");
    step(1'b1, 1'b1, 32'h000000FF, "R2 low byte");
    step(1'b1, 1'b1, 32'hFF000000, "R2 high byte");
    step(1'b1, 1'b1, 32'h80000001, "R2 edge bits");
    // R3 multi-word message
    step(1'b1, 1'b1, 32'h64636261, "R3 w0");
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1, 32'h01020304 * (i + 1), "R3 wn");
    // R4 idle holds
    saved = crc_o;
    step(1'b0, 1'b0, 32'hDEADBEEF, "R4 idle");
    check("R4 held", crc_o, saved);
    step(1'b0, 1'b1, 32'h11111111, "R4 after idle");
    // R5 restart mid message
    step(1'b0, 1'b1, 32'h22222222, "R5 pre");
    step(1'b1, 1'b1, 32'h33333333, "R5 restart");
    step(1'b0, 1'b1, 32'h44444444, "R5 follow");
    // R6 lone start then idle then word
    step(1'b1, 1'b0, 32'h55555555, "R6 lone start");
    step(1'b0, 1'b0, 32'h0, "R6 gap");
    step(1'b0, 1'b1, 32'h00000000, "R6 first word");
    check("R6 const", crc_o, 32'h2144DF1C);
    // R8 random messages with random gaps and restarts
    for (int m = 0; m < 300; m++) begin
      logic rs, rv;
      rs = ($urandom % 16) == 0;
      rv = ($urandom % 4) != 0;
      step(rs, rv, $urandom, "R8 random");
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule